// File: doc/BRIEF.md
# Internal Data RAM with Address Steering

This block holds the 256-byte internal data RAM of an 8-bit accumulator-style core, together with the logic that decides where each access goes. A byte request comes in one of three addressing modes. Register mode picks one of eight working registers in the bank chosen by a 2-bit bank input. Direct mode reaches the RAM only in the lower half and sends anything higher to an external special-function-register (SFR) port. Indirect mode reaches every RAM byte, including the upper half, which is physically separate from the SFRs even though it shares their addresses.

A separate single-bit request addresses 128 flag bits kept in a 16-byte window of the lower RAM. Bit addresses in the upper half go unchanged to an SFR bit port. The byte and bit requests can arrive in the same cycle. Reads return data one cycle after the request. Writes land on the clock edge.

Top module: `idram_unit`

## Requirements
- R1: After reset, `byte_rdata` and `bit_rdata` are 0, and with no request active `sfr_req` and `sfr_bit_req` are low. Reset does not clear the RAM contents.
- R2: Register mode (`byte_mode` = 2'b00) accesses RAM byte `bank_sel`*8 + `byte_addr[2:0]`. Address bits 7..3 are ignored in this mode.
- R3: Direct mode (2'b01) with an address in 0x00..0x7F accesses the same RAM byte that indirect mode reaches at that address.
- R4: Direct mode with an address of 0x80 or above drives `sfr_req` high in the same cycle, with `sfr_we`, `sfr_addr` and `sfr_wdata` equal to the request. It leaves the RAM unchanged. For a read, `byte_rdata` shows `sfr_rdata` from the next cycle on.
- R5: Indirect mode (`byte_mode[1]` = 1) reaches all 256 RAM bytes, the upper 128 included, and never raises `sfr_req`.
- R6: A bit address b in 0x00..0x7F refers to bit b mod 8 of RAM byte 0x20 + b/8. A bit read returns that bit on `bit_rdata` one cycle later.
- R7: A bit write changes only the addressed bit of its byte. The other seven bits keep their values.
- R8: A bit address of 0x80 or above raises `sfr_bit_req` in the same cycle, with `sfr_bit_addr`, `sfr_bit_we` and `sfr_bit_wdata` copied from the request. It leaves the RAM unchanged. For a read, `bit_rdata` shows `sfr_bit_rdata` from the next cycle on.
- R9: Read data appears exactly one cycle after a read request. After a RAM read, the value holds until the next read request on the same port.
- R10: If a byte write and a bit write target the same RAM byte in one cycle, the byte ends up holding the byte write's data and the bit write is dropped.
- R11: A read in the same cycle as a write to the same RAM byte, coming from the other port, returns the data from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the control state |
| bank_sel | input | 2 | Working-register bank used in register mode |
| byte_req | input | 1 | Byte request valid |
| byte_we | input | 1 | Byte request is a write |
| byte_mode | input | 2 | 00 register, 01 direct, 1x indirect |
| byte_addr | input | 8 | Byte address, or register number in bits 2..0 |
| byte_wdata | input | 8 | Byte write data |
| byte_rdata | output | 8 | Byte read data, one cycle after the request |
| bit_req | input | 1 | Bit request valid |
| bit_we | input | 1 | Bit request is a write |
| bit_addr | input | 8 | Bit address |
| bit_wdata | input | 1 | Bit write value |
| bit_rdata | output | 1 | Bit read data, one cycle after the request |
| sfr_req | output | 1 | Direct access forwarded to the SFR side |
| sfr_we | output | 1 | Forwarded access is a write |
| sfr_addr | output | 8 | Forwarded byte address |
| sfr_wdata | output | 8 | Forwarded write data |
| sfr_rdata | input | 8 | SFR read data, valid the cycle after a forwarded read |
| sfr_bit_req | output | 1 | Bit access forwarded to the SFR side |
| sfr_bit_we | output | 1 | Forwarded bit access is a write |
| sfr_bit_addr | output | 8 | Forwarded bit address |
| sfr_bit_wdata | output | 1 | Forwarded bit write value |
| sfr_bit_rdata | input | 1 | SFR bit read data, valid the cycle after a forwarded read |

## Verification
The whole RAM is first written and read back through indirect mode, so every byte holds a known value before the aliasing tests start. Each of the 32 register-mode slots is then written with junk in the upper address bits, and read back in direct mode. This shows whether the bank arithmetic and the masking of those upper bits are right. Direct accesses at the upper addresses are compared against indirect reads of the same addresses, which tells whether a request went to the SFR port or to the upper RAM. Every flag bit is written and read back together with its host byte. Colliding byte and bit writes, and reads that meet a write to the same byte, show which write wins and whether a read returns the old or the new value.

// File: rtl/idram_pkg.sv
package idram_pkg;

  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned BANK_W   = 2;
  localparam int unsigned RSEL_W   = 3;
  localparam int unsigned LANE_W   = 3;
  localparam logic [ADDR_W-1:0] FLAG_BASE = 8'h20;

  typedef enum logic [1:0] {
    AM_REG = 2'b00,
    AM_DIR = 2'b01,
    AM_IND = 2'b10,
    AM_IND_ALT = 2'b11
  } amode_e;

  // working register n of bank k sits at k*8 + n
  function automatic logic [ADDR_W-1:0] reg_byte(input logic [BANK_W-1:0] bank,
                                                 input logic [RSEL_W-1:0] rn);
    return {{(ADDR_W-BANK_W-RSEL_W){1'b0}}, bank, rn};
  endfunction

  // flag bit b lives in byte FLAG_BASE + b/8; caller passes b[6:3]
  function automatic logic [ADDR_W-1:0] flag_host(input logic [3:0] group);
    return FLAG_BASE + {{(ADDR_W-4){1'b0}}, group};
  endfunction

  function automatic logic [DATA_W-1:0] lane_mask(input logic [LANE_W-1:0] lane);
    return {{(DATA_W-1){1'b0}}, 1'b1} << lane;
  endfunction

endpackage

// File: rtl/idram_byte_steer.sv
module idram_byte_steer
  import idram_pkg::*;
(
  input  logic              req,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank,
  output logic              ram_hit,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              sfr_hit
);

  amode_e am;
  assign am = amode_e'(mode);

  always_comb begin
    ram_hit  = 1'b0;
    sfr_hit  = 1'b0;
    ram_addr = addr;
    unique case (am)
      AM_REG: begin
        ram_hit  = req;
        ram_addr = reg_byte(bank, addr[RSEL_W-1:0]);
      end
      AM_DIR: begin
        ram_hit = req & ~addr[ADDR_W-1];
        sfr_hit = req &  addr[ADDR_W-1];
      end
      default: ram_hit = req;
    endcase
  end

endmodule

// File: rtl/idram_bit_steer.sv
module idram_bit_steer
  import idram_pkg::*;
(
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output logic              ram_hit,
  output logic [ADDR_W-1:0] host_addr,
  output logic [LANE_W-1:0] lane,
  output logic              sfr_hit
);

  assign ram_hit   = req & ~addr[ADDR_W-1];
  assign sfr_hit   = req &  addr[ADDR_W-1];
  assign host_addr = flag_host(addr[6:3]);
  assign lane      = addr[LANE_W-1:0];

endmodule

// File: rtl/idram_store.sv
module idram_store
  import idram_pkg::*;
#(
  parameter int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bwr_en,
  input  logic [ADDR_W-1:0] bwr_addr,
  input  logic [DATA_W-1:0] bwr_data,
  input  logic              brd_en,
  input  logic [ADDR_W-1:0] brd_addr,
  output logic [DATA_W-1:0] brd_q,
  input  logic              fwr_en,
  input  logic [ADDR_W-1:0] fwr_addr,
  input  logic [LANE_W-1:0] fwr_lane,
  input  logic              fwr_val,
  input  logic              frd_en,
  input  logic [ADDR_W-1:0] frd_addr,
  input  logic [LANE_W-1:0] frd_lane,
  output logic              frd_q
);

  logic [DATA_W-1:0] mem [DEPTH];

  logic [DATA_W-1:0] brd_cur;
  logic [DATA_W-1:0] frd_cur;
  logic [DATA_W-1:0] fwr_old;
  logic [DATA_W-1:0] fwr_mask;
  logic [DATA_W-1:0] fwr_merged;
  logic              fwr_collide;
  logic              fwr_commit;

  assign brd_cur     = mem[brd_addr];
  assign frd_cur     = mem[frd_addr];
  assign fwr_old     = mem[fwr_addr];
  assign fwr_mask    = lane_mask(fwr_lane);
  assign fwr_merged  = fwr_val ? (fwr_old | fwr_mask) : (fwr_old & ~fwr_mask);
  assign fwr_collide = bwr_en && fwr_en && (bwr_addr == fwr_addr);
  assign fwr_commit  = fwr_en && !fwr_collide;

  always_ff @(posedge clk) begin
    if (bwr_en)     mem[bwr_addr] <= bwr_data;
    if (fwr_commit) mem[fwr_addr] <= fwr_merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brd_q <= '0;
      frd_q <= 1'b0;
    end else begin
      if (brd_en) brd_q <= brd_cur;
      if (frd_en) frd_q <= frd_cur[frd_lane];
    end
  end

  // R10
  byte_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwr_collide |=> mem[$past(bwr_addr)] == $past(bwr_data));

  // R7
  bit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwr_commit && !bwr_en) |=>
      (((mem[$past(fwr_addr)] ^ $past(fwr_old)) & ~$past(fwr_mask)) == '0) &&
      (mem[$past(fwr_addr)][$past(fwr_lane)] == $past(fwr_val)));

  // R11
  rd_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brd_en |=> brd_q == $past(brd_cur));

endmodule

// File: rtl/idram_unit.sv
module idram_unit
  import idram_pkg::*;
#(
  parameter int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              byte_req,
  input  logic              byte_we,
  input  logic [1:0]        byte_mode,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic [DATA_W-1:0] byte_wdata,
  output logic [DATA_W-1:0] byte_rdata,
  input  logic              bit_req,
  input  logic              bit_we,
  input  logic [ADDR_W-1:0] bit_addr,
  input  logic              bit_wdata,
  output logic              bit_rdata,
  output logic              sfr_req,
  output logic              sfr_we,
  output logic [ADDR_W-1:0] sfr_addr,
  output logic [DATA_W-1:0] sfr_wdata,
  input  logic [DATA_W-1:0] sfr_rdata,
  output logic              sfr_bit_req,
  output logic              sfr_bit_we,
  output logic [ADDR_W-1:0] sfr_bit_addr,
  output logic              sfr_bit_wdata,
  input  logic              sfr_bit_rdata
);

  logic              b_ram_hit, b_sfr_hit;
  logic [ADDR_W-1:0] b_ram_addr;
  logic              f_ram_hit, f_sfr_hit;
  logic [ADDR_W-1:0] f_host;
  logic [LANE_W-1:0] f_lane;
  logic              byte_rd, bit_rd;
  logic              ram_bwr, ram_fwr;
  logic [DATA_W-1:0] ram_bq;
  logic              ram_fq;
  logic              byte_from_sfr_q, bit_from_sfr_q;

  idram_byte_steer u_bsteer (
    .req(byte_req), .mode(byte_mode), .addr(byte_addr), .bank(bank_sel),
    .ram_hit(b_ram_hit), .ram_addr(b_ram_addr), .sfr_hit(b_sfr_hit)
  );

  idram_bit_steer u_fsteer (
    .req(bit_req), .addr(bit_addr),
    .ram_hit(f_ram_hit), .host_addr(f_host), .lane(f_lane), .sfr_hit(f_sfr_hit)
  );

  assign byte_rd = byte_req & ~byte_we;
  assign bit_rd  = bit_req & ~bit_we;
  assign ram_bwr = b_ram_hit & byte_we;
  assign ram_fwr = f_ram_hit & bit_we;

  idram_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .bwr_en(ram_bwr), .bwr_addr(b_ram_addr), .bwr_data(byte_wdata),
    .brd_en(b_ram_hit & ~byte_we), .brd_addr(b_ram_addr), .brd_q(ram_bq),
    .fwr_en(ram_fwr), .fwr_addr(f_host), .fwr_lane(f_lane), .fwr_val(bit_wdata),
    .frd_en(f_ram_hit & ~bit_we), .frd_addr(f_host), .frd_lane(f_lane), .frd_q(ram_fq)
  );

  assign sfr_req       = b_sfr_hit;
  assign sfr_we        = byte_we;
  assign sfr_addr      = byte_addr;
  assign sfr_wdata     = byte_wdata;
  assign sfr_bit_req   = f_sfr_hit;
  assign sfr_bit_we    = bit_we;
  assign sfr_bit_addr  = bit_addr;
  assign sfr_bit_wdata = bit_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_from_sfr_q <= 1'b0;
      bit_from_sfr_q  <= 1'b0;
    end else begin
      if (byte_rd) byte_from_sfr_q <= b_sfr_hit;
      if (bit_rd)  bit_from_sfr_q  <= f_sfr_hit;
    end
  end

  assign byte_rdata = byte_from_sfr_q ? sfr_rdata : ram_bq;
  assign bit_rdata  = bit_from_sfr_q ? sfr_bit_rdata : ram_fq;

  // R4
  dir_hi_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_req && byte_mode == 2'b01 && byte_addr[ADDR_W-1]) |-> (sfr_req && !ram_bwr));

  // R5
  ind_no_sfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_req && byte_mode[1]) |-> !sfr_req);

  // R2
  reg_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_req && byte_mode == 2'b00) |-> (b_ram_addr < 32));

  // R8
  bit_hi_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_req && bit_addr[ADDR_W-1]) |-> (sfr_bit_req && !ram_fwr && sfr_bit_addr == bit_addr));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_rd && !byte_from_sfr_q) |=> $stable(byte_rdata));

endmodule

// File: tb/tb_idram_unit.sv
module tb_idram_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bank_sel = '0;
  logic       byte_req = 1'b0, byte_we = 1'b0;
  logic [1:0] byte_mode = '0;
  logic [7:0] byte_addr = '0, byte_wdata = '0;
  logic [7:0] byte_rdata;
  logic       bit_req = 1'b0, bit_we = 1'b0, bit_wdata = 1'b0;
  logic [7:0] bit_addr = '0;
  logic       bit_rdata;
  logic       sfr_req, sfr_we, sfr_bit_req, sfr_bit_we, sfr_bit_wdata;
  logic [7:0] sfr_addr, sfr_wdata, sfr_bit_addr;
  logic [7:0] sfr_rdata;
  logic       sfr_bit_rdata;

  always #5 clk = ~clk;

  idram_unit dut (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
    .byte_req(byte_req), .byte_we(byte_we), .byte_mode(byte_mode),
    .byte_addr(byte_addr), .byte_wdata(byte_wdata), .byte_rdata(byte_rdata),
    .bit_req(bit_req), .bit_we(bit_we), .bit_addr(bit_addr),
    .bit_wdata(bit_wdata), .bit_rdata(bit_rdata),
    .sfr_req(sfr_req), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .sfr_bit_req(sfr_bit_req), .sfr_bit_we(sfr_bit_we), .sfr_bit_addr(sfr_bit_addr),
    .sfr_bit_wdata(sfr_bit_wdata), .sfr_bit_rdata(sfr_bit_rdata)
  );

  // SFR side stand-in: answers a read the cycle after, then holds
  logic [7:0] sfr_last = '0;
  logic [7:0] sfr_bit_last = '0;
  always @(posedge clk) begin
    if (sfr_req && !sfr_we) sfr_last <= sfr_addr;
    if (sfr_bit_req && !sfr_bit_we) sfr_bit_last <= sfr_bit_addr;
  end
  assign sfr_rdata     = {sfr_last[3:0], sfr_last[7:4]};
  assign sfr_bit_rdata = ^sfr_bit_last;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [256];
  logic [7:0] exp_byte = '0;
  logic       exp_bit  = 1'b0;
  string      byte_tag = "R1";
  string      bit_tag  = "R1";

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic breq, input logic bwe, input logic [1:0] bmode,
                      input logic [7:0] baddr, input logic [7:0] bwd, input logic [1:0] bank,
                      input logic treq, input logic twe, input logic [7:0] taddr,
                      input logic twd, input string tag);
    int bi;
    int ti;
    logic exp_s, exp_t;
    byte_req = breq; byte_we = bwe; byte_mode = bmode; byte_addr = baddr;
    byte_wdata = bwd; bank_sel = bank;
    bit_req = treq; bit_we = twe; bit_addr = taddr; bit_wdata = twd;
    #1;
    exp_s = breq && bmode == 2'b01 && baddr >= 8'h80;
    chk(sfr_req == exp_s, exp_s ? "R4" : "R5", "sfr_req", 32'(sfr_req), 32'(exp_s));
    if (exp_s) begin
      chk(sfr_addr == baddr && sfr_we == bwe && (!bwe || sfr_wdata == bwd), "R4",
          "sfr fields", {sfr_we, 8'h0, sfr_wdata, sfr_addr}, {bwe, 8'h0, bwd, baddr});
    end
    exp_t = treq && taddr >= 8'h80;
    chk(sfr_bit_req == exp_t, "R8", "sfr_bit_req", 32'(sfr_bit_req), 32'(exp_t));
    if (exp_t) begin
      chk(sfr_bit_addr == taddr && sfr_bit_we == twe && (!twe || sfr_bit_wdata == twd), "R8",
          "sfr bit fields", {sfr_bit_we, sfr_bit_wdata, sfr_bit_addr},
          {twe, twd, taddr});
    end
    @(posedge clk);
    bi = -1;
    if (breq) begin
      if (bmode == 2'b00)      bi = int'(bank) * 8 + int'(baddr % 8);
      else if (bmode == 2'b01) bi = (baddr < 8'h80) ? int'(baddr) : -1;
      else                     bi = int'(baddr);
    end
    ti = (taddr < 8'h80) ? 32 + int'(taddr) / 8 : -1;
    if (breq && !bwe) begin
      exp_byte = (bi >= 0) ? model[bi] : {baddr[3:0], baddr[7:4]};
      byte_tag = tag;
    end
    if (treq && !twe) begin
      exp_bit = (ti >= 0) ? model[ti][taddr % 8] : ^taddr;
      bit_tag = tag;
    end
    if (breq && bwe && bi >= 0) model[bi] = bwd;
    if (treq && twe && ti >= 0 && !(breq && bwe && bi == ti))
      model[ti][taddr % 8] = twd;
    @(negedge clk);
    chk(byte_rdata == exp_byte, byte_tag, "byte_rdata", 32'(byte_rdata), 32'(exp_byte));
    chk(bit_rdata == exp_bit, bit_tag, "bit_rdata", 32'(bit_rdata), 32'(exp_bit));
  endtask

  task automatic bstep(input logic we, input logic [1:0] mode, input logic [7:0] a,
                       input logic [7:0] d, input logic [1:0] bank, input string tag);
    step(1'b1, we, mode, a, d, bank, 1'b0, 1'b0, 8'h00, 1'b0, tag);
  endtask

  task automatic tstep(input logic we, input logic [7:0] a, input logic v, input string tag);
    step(1'b0, 1'b0, 2'b10, 8'h00, 8'h00, 2'b00, 1'b1, we, a, v, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(byte_rdata == 8'h00, "R1", "byte_rdata after reset", 32'(byte_rdata), 0);
    chk(bit_rdata == 1'b0, "R1", "bit_rdata after reset", 32'(bit_rdata), 0);
    chk(!sfr_req && !sfr_bit_req, "R1", "sfr requests idle",
        32'({sfr_req, sfr_bit_req}), 0);

    // R5 fill whole RAM indirectly, upper half included
    for (int i = 0; i < 256; i++) bstep(1'b1, 2'b10, 8'(i), 8'(i * 7 + 3), 2'b00, "R5");
    for (int i = 0; i < 256; i++) bstep(1'b0, 2'b11, 8'(i), 8'h00, 2'b00, "R5");

    // R3 direct lower half aliases indirect
    for (int i = 0; i < 128; i += 9) begin
      bstep(1'b1, 2'b01, 8'(i), 8'(i ^ 8'h5A), 2'b00, "R3");
      bstep(1'b0, 2'b10, 8'(i), 8'h00, 2'b00, "R3");
    end

    // R2 register banks, junk in the upper address bits
    for (int k = 0; k < 4; k++)
      for (int n = 0; n < 8; n++)
        bstep(1'b1, 2'b00, 8'({5'(k * 3 + n + 1), 3'(n)}), 8'(8'hC0 + k * 8 + n), 2'(k), "R2");
    for (int a = 0; a < 32; a++) bstep(1'b0, 2'b01, 8'(a), 8'h00, 2'b00, "R2");
    for (int k = 0; k < 4; k++) bstep(1'b0, 2'b00, 8'hF8 | 8'(k + 2), 8'h00, 2'(k), "R2");

    // R4 direct upper half goes to SFR, RAM untouched
    bstep(1'b1, 2'b01, 8'h90, 8'hEE, 2'b00, "R4");
    bstep(1'b1, 2'b01, 8'hFF, 8'h11, 2'b00, "R4");
    bstep(1'b0, 2'b10, 8'h90, 8'h00, 2'b00, "R4");
    bstep(1'b0, 2'b10, 8'hFF, 8'h00, 2'b00, "R4");
    bstep(1'b0, 2'b01, 8'hA7, 8'h00, 2'b00, "R4");
    bstep(1'b0, 2'b01, 8'h80, 8'h00, 2'b00, "R4");
    // R9 read data holds through idle cycles and writes elsewhere
    bstep(1'b0, 2'b10, 8'h44, 8'h00, 2'b00, "R9");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 2'b00, 8'h00, 8'h00, 2'b00,
                                     1'b0, 1'b0, 8'h00, 1'b0, "R9");
    bstep(1'b1, 2'b10, 8'h45, 8'h99, 2'b00, "R9");

    // R6 R7 every flag bit written then read with its host byte
    for (int b = 0; b < 128; b++) tstep(1'b1, 8'(b), 1'($urandom_range(0, 1)), "R7");
    for (int b = 0; b < 128; b++)
      step(1'b1, 1'b0, 2'b10, 8'(8'h20 + b / 8), 8'h00, 2'b00,
           1'b1, 1'b0, 8'(b), 1'b0, "R6");

    // R8 upper bit addresses forwarded, RAM untouched
    tstep(1'b1, 8'hD3, 1'b1, "R8");
    tstep(1'b0, 8'hE0, 1'b0, "R8");
    tstep(1'b0, 8'h87, 1'b0, "R8");
    bstep(1'b0, 2'b10, 8'hD3, 8'h00, 2'b00, "R8");

    // R10 byte write and bit write to the same byte
    step(1'b1, 1'b1, 2'b10, 8'h25, 8'hA5, 2'b00, 1'b1, 1'b1, 8'h2E, 1'b0, "R10");
    step(1'b1, 1'b1, 2'b01, 8'h2F, 8'h00, 2'b00, 1'b1, 1'b1, 8'h7A, 1'b1, "R10");
    bstep(1'b0, 2'b10, 8'h25, 8'h00, 2'b00, "R10");
    bstep(1'b0, 2'b10, 8'h2F, 8'h00, 2'b00, "R10");
    // different bytes: both writes land
    step(1'b1, 1'b1, 2'b10, 8'h30, 8'h3C, 2'b00, 1'b1, 1'b1, 8'h01, 1'b1, "R10");
    tstep(1'b0, 8'h01, 1'b0, "R10");
    bstep(1'b0, 2'b10, 8'h30, 8'h00, 2'b00, "R10");

    // R11 reads meeting a write to the same byte see old data
    step(1'b1, 1'b0, 2'b10, 8'h22, 8'h00, 2'b00, 1'b1, 1'b1, 8'h13, 1'b1, "R11");
    step(1'b1, 1'b0, 2'b10, 8'h22, 8'h00, 2'b00, 1'b1, 1'b1, 8'h13, 1'b0, "R11");
    step(1'b1, 1'b1, 2'b10, 8'h21, 8'hFF, 2'b00, 1'b1, 1'b0, 8'h0A, 1'b0, "R11");
    step(1'b1, 1'b1, 2'b10, 8'h21, 8'h00, 2'b00, 1'b1, 1'b0, 8'h0A, 1'b0, "R11");
    tstep(1'b0, 8'h0A, 1'b0, "R11");

    // R1 contents survive a reset
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    exp_byte = 8'h00;
    exp_bit  = 1'b0;
    @(negedge clk);
    chk(byte_rdata == 8'h00 && bit_rdata == 1'b0, "R1", "outputs after second reset",
        32'({bit_rdata, byte_rdata}), 0);
    bstep(1'b0, 2'b10, 8'hC4, 8'h00, 2'b00, "R1");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule